// File: doc/BRIEF.md
# Two-Pass Multiply-Accumulate Unit

This block is a 32-bit integer multiplier with its own 64-bit accumulator pair, HI and LO. It is built around a single 33x17 signed array. The first operand always enters the array at full width. The second operand is fed to the array sixteen bits at a time. When the issue flag asks for it, the operands are zero-extended instead of sign-extended.

The unit looks only at the second operand to decide how many passes an operation needs. If that operand fits in sixteen bits, the product is formed in the cycle of issue. Otherwise a second cycle multiplies by the upper half, shifts that partial product up by sixteen and adds it to the first. During that second cycle the issue port reports not-ready.

The operations are:
- a plain multiply into HI:LO;
- a multiply whose low word comes back on the result port;
- multiply-add and multiply-subtract on HI:LO;
- reads of HI and of LO.

Once accepted, an operation runs to completion whether or not new requests arrive. This lets the unit run alongside an integer pipeline that may be stalled.

Top module: `twopass_mac`

## Requirements
- R1: After reset, `issue_ready` is 1, `res_valid` is 0 and HI:LO holds zero, so reads of HI and LO both return 0.
- R2: The second operand is short when it lies in -32768..32767 (signed flag set) or in 0..65535 (flag clear). Multiply operations (`issue_op` 0 to 3) with a short second operand complete in the issue cycle, and `issue_ready` stays 1, so they can be accepted on consecutive cycles.
- R3: A multiply operation with a long second operand drives `issue_ready` low for exactly the one cycle after it is accepted. Any request held during that cycle is accepted only in the following cycle.
- R4: Op 0 writes the full 64-bit product to HI:LO. The new value is visible to a read accepted in the cycle after completion.
- R5: Op 1 raises `res_valid` for one cycle, in the cycle after completion, with the low 32 bits of the product on `res_data`. HI:LO is left unchanged.
- R6: Op 2 adds the 64-bit product to HI:LO, wrapping modulo 2^64.
- R7: Op 3 subtracts the 64-bit product from HI:LO, wrapping modulo 2^64.
- R8: Op 4 returns HI (bits 63..32) and op 5 returns LO (bits 31..0). The value appears on `res_data` with `res_valid` high in the cycle after the read is accepted.
- R9: With `issue_signed` 1 both operands are two's-complement. With it 0 both are unsigned.
- R10: Op codes 6 and 7 are accepted but have no effect: no result is produced and HI:LO keeps its value.
- R11: An accepted two-pass operation completes one cycle later even when `issue_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Request present |
| issue_op | input | 3 | 0 mult, 1 mult-to-result, 2 mult-add, 3 mult-sub, 4 read HI, 5 read LO, 6/7 no effect |
| issue_signed | input | 1 | 1 for signed operands |
| issue_a | input | 32 | First operand, full width |
| issue_b | input | 32 | Second operand, examined for size |
| issue_ready | output | 1 | Request accepted at this edge when valid |
| res_valid | output | 1 | Result word present |
| res_data | output | 32 | Result word |

## Verification
The hardest cases to reach are those where an operand's width and its signedness interact. One example is a second operand of 0x0000_8000: it is short when unsigned but needs two passes when signed. The other is a two-pass operation followed at once by another request that must wait out the stall. The stimulus drives these operands directly and issues requests back to back without idle cycles. A long random run then mixes operand classes, signedness and op codes, including reads that immediately follow a two-pass accumulate. A behavioural model in the bench, built on 64-bit integer arithmetic, predicts the ready flag and every result on each clock.

// File: rtl/twopass_mac.sv
module twopass_mac #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [2:0]    issue_op,
  input  logic          issue_signed,
  input  logic [DW-1:0] issue_a,
  input  logic [DW-1:0] issue_b,
  output logic          issue_ready,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  localparam int HW = DW / 2;
  localparam int PW = 2 * DW;
  localparam int AW = DW + HW + 2;
  localparam logic [2:0] OP_MULT = 3'd0;
  localparam logic [2:0] OP_MULR = 3'd1;
  localparam logic [2:0] OP_MADD = 3'd2;
  localparam logic [2:0] OP_MSUB = 3'd3;
  localparam logic [2:0] OP_RDHI = 3'd4;
  localparam logic [2:0] OP_RDLO = 3'd5;

  logic                 busy;
  logic [2:0]           pend_op;
  logic signed [DW:0]   pend_a;
  logic signed [HW:0]   pend_bh;
  logic [PW-1:0]        part;
  logic [PW-1:0]        hilo;

  logic                 accept, is_mul, short_b, finish;
  logic [HW-1:0]        b_top;
  logic signed [DW:0]   ma;
  logic signed [HW:0]   mb;
  logic signed [AW-1:0] arr;
  logic [PW-1:0]        arr_x, prod, hilo_nx;
  logic [2:0]           fop;

  assign issue_ready = !busy;
  assign accept      = issue_valid && !busy;
  assign is_mul      = issue_op <= OP_MSUB;
  assign b_top       = issue_b[DW-1:HW];
  assign short_b     = issue_signed ? (b_top == {HW{issue_b[HW-1]}}) : (b_top == '0);

  assign ma  = busy ? pend_a  : {issue_signed & issue_a[DW-1], issue_a};
  assign mb  = busy ? pend_bh : {issue_signed & short_b & issue_b[HW-1], issue_b[HW-1:0]};
  assign arr = ma * mb;
  assign arr_x = {{(PW-AW){arr[AW-1]}}, arr};

  assign prod   = busy ? (part + (arr_x << HW)) : arr_x;
  assign finish = busy || (accept && is_mul && short_b);
  assign fop    = busy ? pend_op : issue_op;

  always_comb begin
    case (fop)
      OP_MADD: hilo_nx = hilo + prod;
      OP_MSUB: hilo_nx = hilo - prod;
      default: hilo_nx = prod;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend_op   <= OP_MULT;
      pend_a    <= '0;
      pend_bh   <= '0;
      part      <= '0;
      hilo      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (finish) begin
        if (fop == OP_MULR) begin
          res_valid <= 1'b1;
          res_data  <= prod[DW-1:0];
        end else begin
          hilo <= hilo_nx;
        end
      end
      if (busy) begin
        busy <= 1'b0;
      end else if (accept) begin
        if (is_mul && !short_b) begin
          busy    <= 1'b1;
          pend_op <= issue_op;
          pend_a  <= ma;
          pend_bh <= {issue_signed & issue_b[DW-1], b_top};
          part    <= arr_x;
        end
        if (issue_op == OP_RDHI) begin
          res_valid <= 1'b1;
          res_data  <= hilo[PW-1:DW];
        end
        if (issue_op == OP_RDLO) begin
          res_valid <= 1'b1;
          res_data  <= hilo[DW-1:0];
        end
      end
    end
  end

  // R3
  long_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && is_mul && !short_b) |=> !issue_ready);
  // R3
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready |=> issue_ready);
  // R2
  short_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && is_mul && short_b) |=> issue_ready);
  // R8
  read_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (issue_op == OP_RDHI || issue_op == OP_RDLO)) |=> res_valid);
  // R10
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && issue_op >= 3'd6) |=> (!res_valid && $stable(hilo)));
  // R5
  mulr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend_op == OP_MULR) |=> (res_valid && $stable(hilo)));
endmodule

// File: tb/twopass_mac_tb.sv
`timescale 1ns/1ps
module twopass_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_op = 3'd0;
  logic        issue_signed = 1'b0;
  logic [31:0] issue_a = '0;
  logic [31:0] issue_b = '0;
  logic        issue_ready, res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  string focus = "";

  always #2.5 clk = ~clk;

  twopass_mac u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_signed(issue_signed), .issue_a(issue_a), .issue_b(issue_b),
    .issue_ready(issue_ready), .res_valid(res_valid), .res_data(res_data)
  );

  bit          m_busy;
  logic [2:0]  m_op;
  bit          m_s;
  logic [31:0] m_a, m_b;
  logic [63:0] m_hilo;
  bit          m_rv;
  logic [31:0] m_rd;
  string       m_tag, m_htag;

  function automatic logic [63:0] ref_prod(bit s, logic [31:0] a, logic [31:0] b);
    longint x, y;
    if (s) begin x = longint'($signed(a)); y = longint'($signed(b)); end
    else   begin x = longint'({32'd0, a}); y = longint'({32'd0, b}); end
    return 64'(x * y);
  endfunction

  function automatic bit fits(bit s, logic [31:0] b);
    if (s) return ($signed(b) >= -32768) && ($signed(b) <= 32767);
    return b < 32'd65536;
  endfunction

  task automatic apply(logic [2:0] op, bit s, logic [31:0] a, logic [31:0] b);
    logic [63:0] p = ref_prod(s, a, b);
    case (op)
      3'd0: begin m_hilo = p; m_htag = "R4"; end
      3'd1: begin m_rv = 1; m_rd = p[31:0]; m_tag = "R5"; end
      3'd2: begin m_hilo = m_hilo + p; m_htag = "R6"; end
      3'd3: begin m_hilo = m_hilo - p; m_htag = "R7"; end
      3'd4: begin m_rv = 1; m_rd = m_hilo[63:32]; m_tag = m_htag; end
      3'd5: begin m_rv = 1; m_rd = m_hilo[31:0]; m_tag = m_htag; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_hilo = '0; m_rv = 0; m_htag = "R8";
    end else begin
      m_rv = 0;
      if (m_busy) begin
        apply(m_op, m_s, m_a, m_b);
        m_busy = 0;
      end else if (issue_valid) begin
        if (issue_op <= 3'd3 && !fits(issue_signed, issue_b)) begin
          m_busy = 1; m_op = issue_op; m_s = issue_signed; m_a = issue_a; m_b = issue_b;
        end else begin
          apply(issue_op, issue_signed, issue_a, issue_b);
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(focus != "" ? focus : "R3", 32'(issue_ready), 32'(!m_busy));
      check(focus != "" ? focus : (m_rv ? m_tag : "R10"), 32'(res_valid), 32'(m_rv));
      if (m_rv) check(focus != "" ? focus : m_tag, res_data, m_rd);
    end
  end

  task automatic send(logic [2:0] op, bit s, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    issue_valid = 1; issue_op = op; issue_signed = s; issue_a = a; issue_b = b;
    while (m_busy) @(negedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    issue_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] pick_b();
    case ($urandom % 5)
      0: return $urandom % 32768;
      1: return 32'hFFFF_0000 | ($urandom % 65536);
      2: return $urandom % 65536;
      3: return 32'h0000_8000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    focus = "R1";
    @(negedge clk);
    check("R1", 32'(issue_ready), 32'd1);
    check("R1", 32'(res_valid), 32'd0);
    send(3'd4, 0, 0, 0);
    send(3'd5, 0, 0, 0);
    idle(2);

    focus = "R2";
    send(3'd1, 1, 32'h1234_5678, 32'hFFFF_8000);
    send(3'd1, 0, 32'h8765_4321, 32'h0000_FFFF);
    send(3'd1, 0, 32'hFFFF_FFFF, 32'h0000_8000);
    send(3'd0, 1, 32'h8000_0000, 32'h0000_7FFF);
    send(3'd4, 0, 0, 0);
    idle(2);

    focus = "R3";
    send(3'd1, 1, 32'h0001_0003, 32'h0000_8000);
    send(3'd0, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    send(3'd1, 0, 32'h0000_0011, 32'h0000_0022);
    send(3'd2, 1, 32'h7FFF_FFFF, 32'h8000_0000);
    send(3'd4, 0, 0, 0);
    send(3'd5, 0, 0, 0);
    idle(2);

    focus = "R9";
    send(3'd0, 1, 32'hFFFF_FFFF, 32'h0000_0002);
    send(3'd4, 0, 0, 0);
    send(3'd0, 0, 32'hFFFF_FFFF, 32'h0000_0002);
    send(3'd4, 0, 0, 0);
    send(3'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(3'd4, 0, 0, 0);
    send(3'd5, 0, 0, 0);
    idle(2);

    focus = "R10";
    send(3'd6, 1, 32'h5555_5555, 32'h7777_7777);
    send(3'd7, 0, 32'h1, 32'h1);
    send(3'd4, 0, 0, 0);
    send(3'd5, 0, 0, 0);
    idle(2);

    focus = "R11";
    send(3'd3, 1, 32'h0BAD_CAFE, 32'h1234_5678);
    idle(3);
    send(3'd5, 0, 0, 0);
    send(3'd4, 0, 0, 0);
    idle(2);

    focus = "";
    send(3'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(3'd2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(3'd4, 0, 0, 0);
    send(3'd3, 1, 32'h8000_0000, 32'h8000_0000);
    send(3'd5, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      send(3'($urandom % 8), 1'($urandom % 2), $urandom, pick_b());
      if ($urandom % 10 == 0) idle($urandom % 3);
    end
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule